// File: doc/BRIEF.md
# TDD Link Acquisition Controller

This block runs the link-level state machine of one end of a time-division duplex radio link. Each end is set up as either the master or the slave. A separate receive path reports each frame it finishes decoding as a one-cycle event. The event carries the frame type (acquisition, empty or data), the number of symbol errors found in the identity field, and a frame-error flag. From these events the controller chooses which frame type goes out in the next transmit slot. It also keeps two status flags. `lock` means an acquisition frame has been accepted. `rlock` means an empty frame has been accepted, so the far end has locked as well.

The link is brought up in four steps. The master sends acquisition frames. The slave answers a valid one with its own acquisition frame. The master then sends an empty frame, and the slave echoes it. After that, both ends exchange data frames. Frame errors on an established link can drop the link at once. In sticky mode they are instead tolerated up to a programmable number of consecutive bad frames. A slave can be made receive-only, so that it follows the handshake without ever transmitting. The control fields are loaded through a single write strobe. A soft reset input returns the controller to standby.

Top module: `link_acq_ctrl`

## Requirements
- R1: After reset, `tx_type` is 00 (send nothing) and `lock` and `rlock` are low. The control fields reset to start=0, master=0, receive-only=0, sticky=0 and error limit=3.
- R2: While the start field is clear, the controller stays in standby: `tx_type`=00, `lock`=0 and `rlock`=0. Clearing start, or pulsing `soft_rst` (which clears start), brings the outputs to standby one clock after the start register changes.
- R3: A started master sends acquisition frames (`tx_type`=01). A valid received acquisition frame (`rx_type`=01) sets `lock` and switches transmission to empty frames (`tx_type`=10).
- R4: A master sending empty frames that then receives a valid empty frame (`rx_type`=10) sets `rlock` and sends data frames (`tx_type`=11) from then on.
- R5: A started slave transmits nothing until it receives a valid acquisition frame. It then sets `lock` and sends acquisition frames. A valid empty frame next sets `rlock` and makes it send empty frames. A valid data frame (`rx_type`=11) after that makes it send data frames.
- R6: A received frame is valid only when `rx_ferr` is low and `rx_id_err` is 2 or less. A frame with 3 or more identity symbol errors is handled exactly like a frame error.
- R7: A slave with receive-only set always drives `tx_type`=00. Its `lock` and `rlock` still follow the handshake.
- R8: With sticky mode off, one invalid frame on an established link clears `lock` and `rlock`. The controller returns to its first acquisition step: a master sends 01, a slave sends nothing.
- R9: With sticky mode on and error limit N, the link keeps sending data frames with both flags held through N consecutive invalid frames. The link is lost on invalid frame N+1, and N=0 gives immediate loss.
- R10: A valid data frame received on the link resets the count of consecutive invalid frames to zero.
- R11: An invalid frame received before the link is established sends the controller back to its first acquisition step with `lock` and `rlock` clear. Sticky tolerance does not apply at this stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous pulse that clears the start field |
| cfg_wr | input | 1 | Load strobe for the control fields below |
| cfg_start | input | 1 | Start field value |
| cfg_master | input | 1 | Role field value: 1 = master, 0 = slave |
| cfg_rx_only | input | 1 | Receive-only field value (applies to a slave) |
| cfg_sticky | input | 1 | Sticky frame-error tolerance enable value |
| cfg_err_limit | input | 4 | Number of consecutive invalid frames tolerated in sticky mode |
| rx_evt | input | 1 | One-cycle strobe: a receive frame has been decoded |
| rx_type | input | 2 | Decoded frame type: 01 acquisition, 10 empty, 11 data |
| rx_ferr | input | 1 | Frame error flag for the frame reported by `rx_evt` |
| rx_id_err | input | 4 | Symbol errors counted in the identity field |
| tx_type | output | 2 | Frame to send next: 00 none, 01 acquisition, 10 empty, 11 data |
| lock | output | 1 | An acquisition frame has been accepted and the link is still held |
| rlock | output | 1 | An empty frame has been accepted and the link is still held |

## Verification
On every cycle, the bound checker enforces several relations. `rlock` never stands without `lock`. A cleared start field empties the outputs on the next clock. A receive-only slave never transmits. A rising `lock` is always preceded by a valid acquisition event. A frame with too many identity errors never produces a lock. A non-sticky error on a locked link clears both flags. The sticky tolerance window cannot be checked by those relations alone: its exact length, its reset by good data frames, and the different ordering of the master and slave handshakes only show up in the bench's scenarios. The bench checks these against its own behavioural model.

// File: rtl/link_acq_pkg.sv
package link_acq_pkg;

  typedef enum logic [1:0] {
    FR_NONE  = 2'b00,
    FR_ACQ   = 2'b01,
    FR_EMPTY = 2'b10,
    FR_DATA  = 2'b11
  } frame_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_M_ACQ,
    ST_M_EMPTY,
    ST_S_LISTEN,
    ST_S_ACQ,
    ST_S_EMPTY,
    ST_LINK
  } lstate_t;

  typedef struct packed {
    logic start;
    logic master;
    logic rx_only;
    logic sticky;
  } ctl_t;

endpackage

// File: rtl/link_cfg_regs.sv
module link_cfg_regs
  import link_acq_pkg::*;
#(
  parameter int LIM_W   = 4,
  parameter int LIM_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  ctl_t             wr_ctl,
  input  logic [LIM_W-1:0] wr_lim,
  output ctl_t             ctl_q,
  output logic [LIM_W-1:0] lim_q
);

  localparam logic [LIM_W-1:0] LimRst = LIM_W'(LIM_RST);

  ctl_t             ctl_d;
  logic [LIM_W-1:0] lim_d;

  always_comb begin
    ctl_d = ctl_q;
    lim_d = lim_q;
    if (wr_en) begin
      ctl_d = wr_ctl;
      lim_d = wr_lim;
    end
    if (soft_rst) ctl_d.start = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      lim_q <= LimRst;
    end else begin
      ctl_q <= ctl_d;
      lim_q <= lim_d;
    end
  end

endmodule

// File: rtl/link_err_tracker.sv
module link_err_tracker #(
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [LIM_W-1:0] limit,
  output logic             spent
);

  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_d;
  logic             cnt_en;

  assign spent  = (cnt_q >= limit);
  assign cnt_en = clr | inc;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + LIM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/link_fsm.sv
module link_fsm
  import link_acq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ctl_t   ctl,
  input  logic   good_acq,
  input  logic   good_empty,
  input  logic   good_data,
  input  logic   bad,
  input  logic   spent,
  output frame_t tx_frame,
  output logic   lock_q,
  output logic   rlock_q,
  output logic   err_inc,
  output logic   err_clr
);

  lstate_t st_q, st_d;
  logic    lock_d, rlock_d;
  lstate_t first_st;
  logic    loss;
  frame_t  raw_tx;

  assign first_st = ctl.master ? ST_M_ACQ : ST_S_LISTEN;
  assign loss     = (st_q == ST_LINK) && bad && (!ctl.sticky || spent);
  assign err_inc  = ctl.start && (st_q == ST_LINK) && bad && ctl.sticky && !spent;
  assign err_clr  = (st_q != ST_LINK) || good_data;

  always_comb begin
    st_d    = st_q;
    lock_d  = lock_q;
    rlock_d = rlock_q;
    if (!ctl.start) begin
      st_d    = ST_IDLE;
      lock_d  = 1'b0;
      rlock_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = first_st;
        ST_M_ACQ: begin
          if (good_acq) begin
            st_d   = ST_M_EMPTY;
            lock_d = 1'b1;
          end
        end
        ST_M_EMPTY: begin
          if (bad) begin
            st_d    = ST_M_ACQ;
            lock_d  = 1'b0;
            rlock_d = 1'b0;
          end else if (good_empty) begin
            st_d    = ST_LINK;
            rlock_d = 1'b1;
          end
        end
        ST_S_LISTEN: begin
          if (good_acq) begin
            st_d   = ST_S_ACQ;
            lock_d = 1'b1;
          end
        end
        ST_S_ACQ: begin
          if (bad) begin
            st_d    = ST_S_LISTEN;
            lock_d  = 1'b0;
            rlock_d = 1'b0;
          end else if (good_empty) begin
            st_d    = ST_S_EMPTY;
            rlock_d = 1'b1;
          end
        end
        ST_S_EMPTY: begin
          if (bad) begin
            st_d    = ST_S_LISTEN;
            lock_d  = 1'b0;
            rlock_d = 1'b0;
          end else if (good_data) begin
            st_d = ST_LINK;
          end
        end
        ST_LINK: begin
          if (loss) begin
            st_d    = first_st;
            lock_d  = 1'b0;
            rlock_d = 1'b0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lock_q  <= 1'b0;
      rlock_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      lock_q  <= lock_d;
      rlock_q <= rlock_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_M_ACQ, ST_S_ACQ:     raw_tx = FR_ACQ;
      ST_M_EMPTY, ST_S_EMPTY: raw_tx = FR_EMPTY;
      ST_LINK:                raw_tx = FR_DATA;
      default:                raw_tx = FR_NONE;
    endcase
    tx_frame = (ctl.rx_only && !ctl.master) ? FR_NONE : raw_tx;
  end

endmodule

// File: rtl/link_acq_ctrl.sv
module link_acq_ctrl
  import link_acq_pkg::*;
#(
  parameter int LIM_W      = 4,
  parameter int LIM_RST    = 3,
  parameter int ID_SYM_W   = 4,
  parameter int ID_ERR_MAX = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                cfg_wr,
  input  logic                cfg_start,
  input  logic                cfg_master,
  input  logic                cfg_rx_only,
  input  logic                cfg_sticky,
  input  logic [LIM_W-1:0]    cfg_err_limit,
  input  logic                rx_evt,
  input  logic [1:0]          rx_type,
  input  logic                rx_ferr,
  input  logic [ID_SYM_W-1:0] rx_id_err,
  output logic [1:0]          tx_type,
  output logic                lock,
  output logic                rlock
);

  localparam logic [ID_SYM_W-1:0] IdErrMax = ID_SYM_W'(ID_ERR_MAX);

  logic             rst_meta, rst_sync;
  ctl_t             wr_ctl, ctl_q;
  logic [LIM_W-1:0] lim_q;
  logic             frame_ok, good_acq, good_empty, good_data, bad;
  logic             spent, err_inc, err_clr;
  frame_t           tx_frame;
  logic             start_q, master_q, rx_only_q, sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign wr_ctl = '{start: cfg_start, master: cfg_master,
                    rx_only: cfg_rx_only, sticky: cfg_sticky};

  link_cfg_regs #(.LIM_W(LIM_W), .LIM_RST(LIM_RST)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync),
    .soft_rst(soft_rst),
    .wr_en   (cfg_wr),
    .wr_ctl  (wr_ctl),
    .wr_lim  (cfg_err_limit),
    .ctl_q   (ctl_q),
    .lim_q   (lim_q)
  );

  assign frame_ok   = rx_evt && !rx_ferr && (rx_id_err <= IdErrMax);
  assign bad        = rx_evt && !frame_ok;
  assign good_acq   = frame_ok && (rx_type == FR_ACQ);
  assign good_empty = frame_ok && (rx_type == FR_EMPTY);
  assign good_data  = frame_ok && (rx_type == FR_DATA);

  link_err_tracker #(.LIM_W(LIM_W)) u_err (
    .clk  (clk),
    .rst_n(rst_sync),
    .clr  (err_clr),
    .inc  (err_inc),
    .limit(lim_q),
    .spent(spent)
  );

  link_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync),
    .ctl       (ctl_q),
    .good_acq  (good_acq),
    .good_empty(good_empty),
    .good_data (good_data),
    .bad       (bad),
    .spent     (spent),
    .tx_frame  (tx_frame),
    .lock_q    (lock),
    .rlock_q   (rlock),
    .err_inc   (err_inc),
    .err_clr   (err_clr)
  );

  assign tx_type   = tx_frame;
  assign start_q   = ctl_q.start;
  assign master_q  = ctl_q.master;
  assign rx_only_q = ctl_q.rx_only;
  assign sticky_q  = ctl_q.sticky;

endmodule

// File: rtl/link_acq_ctrl_chk.sv
module link_acq_ctrl_chk #(
  parameter int ID_SYM_W   = 4,
  parameter int ID_ERR_MAX = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rx_evt,
  input logic [1:0]          rx_type,
  input logic                rx_ferr,
  input logic [ID_SYM_W-1:0] rx_id_err,
  input logic [1:0]          tx_type,
  input logic                lock,
  input logic                rlock,
  input logic                start_q,
  input logic                master_q,
  input logic                rx_only_q,
  input logic                sticky_q
);

  localparam logic [ID_SYM_W-1:0] IdErrMax = ID_SYM_W'(ID_ERR_MAX);

  // R4 / R5: the far-end flag only exists on top of the local lock
  assert_rlock_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rlock |-> lock);

  assert_standby_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |=> (tx_type == 2'b00 && !lock && !rlock));

  assert_rx_only_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_only_q && !master_q) |-> (tx_type == 2'b00));

  assert_lock_from_acq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(rx_evt && rx_type == 2'b01 && !rx_ferr && rx_id_err <= IdErrMax));

  assert_id_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock && rx_evt && rx_id_err > IdErrMax) |=> !lock);

  assert_nonsticky_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rlock && rx_evt && rx_ferr && !sticky_q) |=> (!lock && !rlock));

endmodule

bind link_acq_ctrl link_acq_ctrl_chk #(.ID_SYM_W(ID_SYM_W), .ID_ERR_MAX(ID_ERR_MAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_evt   (rx_evt),
  .rx_type  (rx_type),
  .rx_ferr  (rx_ferr),
  .rx_id_err(rx_id_err),
  .tx_type  (tx_type),
  .lock     (lock),
  .rlock    (rlock),
  .start_q  (start_q),
  .master_q (master_q),
  .rx_only_q(rx_only_q),
  .sticky_q (sticky_q)
);

// File: tb/tb_link_acq_ctrl.sv
`timescale 1ns/1ps
module tb_link_acq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       soft_rst, cfg_wr, cfg_start, cfg_master, cfg_rx_only, cfg_sticky;
  logic [3:0] cfg_err_limit;
  logic       rx_evt, rx_ferr;
  logic [1:0] rx_type;
  logic [3:0] rx_id_err;
  logic [1:0] tx_type;
  logic       lock, rlock;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  link_acq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
    .cfg_start(cfg_start), .cfg_master(cfg_master), .cfg_rx_only(cfg_rx_only),
    .cfg_sticky(cfg_sticky), .cfg_err_limit(cfg_err_limit),
    .rx_evt(rx_evt), .rx_type(rx_type), .rx_ferr(rx_ferr), .rx_id_err(rx_id_err),
    .tx_type(tx_type), .lock(lock), .rlock(rlock)
  );

  // Behavioural reference: phase 0 standby, 1 master acq, 2 master empty,
  // 3 slave listen, 4 slave acq, 5 slave empty, 6 linked
  int m_ph, m_cnt, m_lim;
  bit m_lock, m_rlock, m_start, m_master, m_rxo, m_sticky;

  function automatic void drop_to(int ph);
    m_ph = ph; m_lock = 0; m_rlock = 0; m_cnt = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_lock = 0; m_rlock = 0; m_cnt = 0;
      m_start = 0; m_master = 0; m_rxo = 0; m_sticky = 0; m_lim = 3;
    end else begin
      bit good, badf;
      int first;
      good  = rx_evt && !rx_ferr && (rx_id_err <= 2);
      badf  = rx_evt && !good;
      first = m_master ? 1 : 3;
      if (!m_start) drop_to(0);
      else case (m_ph)
        0: m_ph = first;
        1: if (good && rx_type == 2'b01) begin m_ph = 2; m_lock = 1; end
        2: if (badf) drop_to(1);
           else if (good && rx_type == 2'b10) begin m_ph = 6; m_rlock = 1; end
        3: if (good && rx_type == 2'b01) begin m_ph = 4; m_lock = 1; end
        4: if (badf) drop_to(3);
           else if (good && rx_type == 2'b10) begin m_ph = 5; m_rlock = 1; end
        5: if (badf) drop_to(3);
           else if (good && rx_type == 2'b11) m_ph = 6;
        default: begin
          if (badf) begin
            if (!m_sticky || m_cnt >= m_lim) drop_to(first);
            else m_cnt++;
          end else if (good && rx_type == 2'b11) m_cnt = 0;
        end
      endcase
      if (cfg_wr) begin
        m_start = cfg_start; m_master = cfg_master; m_rxo = cfg_rx_only;
        m_sticky = cfg_sticky; m_lim = int'(cfg_err_limit);
      end
      if (soft_rst) m_start = 0;
    end
  end

  function automatic logic [1:0] model_tx();
    if (m_rxo && !m_master) return 2'b00;
    case (m_ph)
      1, 4: return 2'b01;
      2, 5: return 2'b10;
      6:    return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (tx_type !== model_tx() || lock !== m_lock || rlock !== m_rlock) begin
        errors++;
        $display("FAIL model compare (R3/R5/R9): tx=%b lock=%b rlock=%b, expected tx=%b lock=%b rlock=%b",
                 tx_type, lock, rlock, model_tx(), m_lock, m_rlock);
      end
    end
  end

  task automatic expect_out(string req, logic [1:0] tx, bit l, bit r);
    checks++;
    if (tx_type !== tx || lock !== l || rlock !== r) begin
      errors++;
      $display("FAIL %s: tx=%b lock=%b rlock=%b, expected tx=%b lock=%b rlock=%b",
               req, tx_type, lock, rlock, tx, l, r);
    end
  endtask

  task automatic set_cfg(bit s, bit m, bit ro, bit st, logic [3:0] lim);
    @(negedge clk);
    cfg_wr = 1; cfg_start = s; cfg_master = m; cfg_rx_only = ro;
    cfg_sticky = st; cfg_err_limit = lim;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic frame(logic [1:0] t, logic [3:0] ie, bit fe);
    @(negedge clk);
    rx_evt = 1; rx_type = t; rx_id_err = ie; rx_ferr = fe;
    @(negedge clk);
    rx_evt = 0; rx_type = 2'b00; rx_id_err = 0; rx_ferr = 0;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; soft_rst = 0; cfg_wr = 0; cfg_start = 0; cfg_master = 0;
    cfg_rx_only = 0; cfg_sticky = 0; cfg_err_limit = 0;
    rx_evt = 0; rx_type = 0; rx_ferr = 0; rx_id_err = 0;
    tick(3);
    rst_n = 1;
    tick(4);
    expect_out("R1 reset state", 2'b00, 0, 0);
    frame(2'b01, 0, 0);
    expect_out("R2 not started ignores frames", 2'b00, 0, 0);

    // Master handshake
    set_cfg(1, 1, 0, 0, 3); tick(1);
    expect_out("R3 master sends acquisition", 2'b01, 0, 0);
    frame(2'b01, 3, 0);
    expect_out("R6 three ID errors rejected", 2'b01, 0, 0);
    frame(2'b01, 2, 0);
    expect_out("R6 two ID errors accepted, R3 lock", 2'b10, 1, 0);
    frame(2'b11, 0, 1);
    expect_out("R11 error during acquisition", 2'b01, 0, 0);
    frame(2'b01, 0, 0);
    frame(2'b10, 0, 0);
    expect_out("R4 master linked", 2'b11, 1, 1);
    frame(2'b11, 0, 1);
    expect_out("R8 non-sticky loss master", 2'b01, 0, 0);

    // Standby via start clear, then via soft reset
    frame(2'b01, 0, 0); frame(2'b10, 0, 0);
    set_cfg(0, 1, 0, 0, 3); tick(1);
    expect_out("R2 start cleared", 2'b00, 0, 0);
    set_cfg(1, 1, 0, 0, 3); tick(1);
    frame(2'b01, 0, 0); frame(2'b10, 0, 0);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    tick(1);
    expect_out("R2 soft reset standby", 2'b00, 0, 0);
    tick(2);
    expect_out("R2 soft reset holds standby", 2'b00, 0, 0);

    // Slave handshake
    set_cfg(1, 0, 0, 0, 3); tick(1);
    expect_out("R5 slave listens silently", 2'b00, 0, 0);
    frame(2'b01, 1, 0);
    expect_out("R5 slave answers acquisition", 2'b01, 1, 0);
    frame(2'b10, 0, 0);
    expect_out("R5 slave answers empty", 2'b10, 1, 1);
    frame(2'b11, 0, 0);
    expect_out("R5 slave sends data", 2'b11, 1, 1);

    // Sticky tolerance, limit 2
    set_cfg(1, 0, 0, 1, 2);
    frame(2'b11, 0, 1);
    expect_out("R9 first tolerated error", 2'b11, 1, 1);
    frame(2'b11, 5, 0);
    expect_out("R9 second tolerated error", 2'b11, 1, 1);
    frame(2'b11, 0, 0);
    frame(2'b11, 0, 1); frame(2'b11, 0, 1);
    expect_out("R10 count cleared by data frame", 2'b11, 1, 1);
    frame(2'b11, 0, 1);
    expect_out("R9 loss after limit exceeded", 2'b00, 0, 0);

    // Sticky with limit 0
    frame(2'b01, 0, 0); frame(2'b10, 0, 0); frame(2'b11, 0, 0);
    set_cfg(1, 0, 0, 1, 0);
    frame(2'b11, 0, 1);
    expect_out("R9 limit zero immediate loss", 2'b00, 0, 0);

    // Receive-only slave
    set_cfg(1, 0, 1, 0, 3);
    frame(2'b01, 0, 0);
    expect_out("R7 receive-only after acquisition", 2'b00, 1, 0);
    frame(2'b10, 0, 0);
    expect_out("R7 receive-only after empty", 2'b00, 1, 1);
    frame(2'b11, 0, 0);
    expect_out("R7 receive-only linked", 2'b00, 1, 1);

    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule